// File: doc/BRIEF.md
# Slip-Tolerant Burst CRC Checker

This block sits after symbol demodulation in a burst receiver. It takes the recovered serial bit stream one bit per strobe and locates a 105-bit CRC-protected codeword within each burst. The codeword's position may have slipped by a whole number of 2-bit symbols. To allow for this, seven CRC evaluators run side by side. Each is tied to one candidate alignment on an even-bit grid from −6 to +6 bits around a nominal 6-bit delay from the burst marker.

When the window of the latest-starting alignment has been consumed, the block gives a one-cycle verdict. The verdict says whether any alignment produced a zero remainder and which slip won. It also carries the 90 payload bits of the winning alignment in parallel. If nothing passes, no payload is offered. The generator polynomial and the register seed are parameters.

Top module: `slip_crc_checker`

## Requirements
- R1: After reset, `res_vld` and `res_pass` are 0, and `res_slip` and `res_payload` are all zeros.
- R2: The CRC is computed MSB-first with the default generator x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (parameter value 15'h4599), a zero seed and no output inversion. An alignment passes when the remainder over its 105 bits (90 data bits followed by 15 check bits) is zero. Bit index 0 is the bit accepted together with `burst_start`. The nominal alignment starts at index 6. On a pass, `res_payload[89]` is the first data bit received and `res_payload[0]` is the last.
- R3: The candidate starting at index 6+s, for s in {−6,−4,−2,0,2,4,6}, is detected on its own. `res_slip` reports s as a 4-bit two's complement number (for example −6 = 4'b1010).
- R4: When no alignment passes, `res_vld` still pulses, with `res_pass`=0, `res_slip`=0 and `res_payload`=0.
- R5: `res_vld` is high for exactly one cycle, in the cycle after the clock edge that accepts bit index 116. It pulses once per burst.
- R6: When several alignments pass, the one with the smallest |s| wins. On equal distance, the negative slip wins.
- R7: Cycles with `bit_vld` low have no effect, whatever `bit_in` and `burst_start` carry.
- R8: A `burst_start` accepted before index 116 drops the burst in progress. No verdict is given for it, and the new burst is evaluated from its own index 0.
- R9: Bits accepted after index 116 and before the next `burst_start` are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial recovered bit |
| burst_start | input | 1 | Marks the accepted bit as index 0 of a new burst |
| res_vld | output | 1 | One-cycle verdict strobe |
| res_pass | output | 1 | Some alignment had a zero remainder |
| res_slip | output | 4 | Winning slip in bits, two's complement |
| res_payload | output | 90 | Winning alignment's data bits, first received at MSB |

## Verification
The hardest case to reach is several alignments passing at once. Random noise almost never yields even one extra zero remainder. The stimulus therefore builds codewords whose leading data bits are zero and surrounds them with zeros. Because the generator is coprime with x, shifting such a codeword keeps it a multiple of the generator, so the neighbouring alignments pass too. An all-zero burst makes every alignment pass. In both cases the bench model, which restates the selection as a fixed preference list, must agree with the winner the block reports.

// File: rtl/slipcrc_pkg.sv
package slipcrc_pkg;

  // One MSB-first LFSR step over a register of width w (w <= 32).
  function automatic logic [31:0] crc_step(input logic [31:0] r, input logic b,
                                           input logic [31:0] poly, input int w);
    logic [31:0] mask;
    logic [31:0] nxt;
    logic        fb;
    mask = (32'd1 << w) - 32'd1;
    fb   = r[w-1] ^ b;
    nxt  = (r << 1) & mask;
    if (fb) nxt = nxt ^ (poly & mask);
    return nxt;
  endfunction

  // Selection cost: distance from the centre lane first, positive side loses ties.
  function automatic int slip_cost(input int k, input int n);
    int c;
    int d;
    c = (n - 1) / 2;
    d = (k > c) ? (k - c) : (c - k);
    return 2 * d + ((k > c) ? 1 : 0);
  endfunction

  // Signed slip in bits represented by lane k.
  function automatic int lane_slip(input int k, input int step, input int span);
    return k * step - span;
  endfunction

endpackage

// File: rtl/burst_crc_lane.sv
module burst_crc_lane #(
  parameter int CRC_W = 15,
  parameter int CW_W  = 105,
  parameter int IDX_W = 7,
  parameter int START = 0,
  parameter logic [CRC_W-1:0] POLY = 15'h4599,
  parameter logic [CRC_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic             bit_in,
  output logic             rem_zero
);
  logic [CRC_W-1:0] crc;
  logic [CRC_W-1:0] seed;
  logic             in_win;
  logic             first;

  assign in_win = take && (int'(idx) >= START) && (int'(idx) < START + CW_W);
  assign first  = (int'(idx) == START);
  assign seed   = first ? INIT : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= '0;
    else if (in_win)
      crc <= CRC_W'(slipcrc_pkg::crc_step(32'(seed), bit_in, 32'(POLY), CRC_W));
  end

  assign rem_zero = (crc == '0);

  // R7: outside its own window a lane's register does not move
  a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> $stable(crc));

endmodule

// File: rtl/slip_pick.sv
module slip_pick #(
  parameter int N_SLIP = 7,
  parameter int SEL_W  = 3
) (
  input  logic [N_SLIP-1:0] zero,
  output logic              any,
  output logic [SEL_W-1:0]  win
);
  int best;

  always_comb begin
    best = 2 * N_SLIP + 2;
    win  = '0;
    for (int k = 0; k < N_SLIP; k++) begin
      if (zero[k] && slipcrc_pkg::slip_cost(k, N_SLIP) < best) begin
        best = slipcrc_pkg::slip_cost(k, N_SLIP);
        win  = SEL_W'(k);
      end
    end
  end

  assign any = |zero;

endmodule

// File: rtl/slip_crc_checker.sv
module slip_crc_checker #(
  parameter int DATA_W    = 90,
  parameter int CRC_W     = 15,
  parameter int NOM_DLY   = 6,
  parameter int SLIP_STEP = 2,
  parameter int N_SLIP    = 7,
  parameter logic [CRC_W-1:0] POLY = 15'h4599,
  parameter logic [CRC_W-1:0] INIT = '0,
  localparam int SPAN   = ((N_SLIP - 1) / 2) * SLIP_STEP,
  localparam int SLIP_W = $clog2(SPAN + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              burst_start,
  output logic              res_vld,
  output logic              res_pass,
  output logic [SLIP_W-1:0] res_slip,
  output logic [DATA_W-1:0] res_payload
);
  localparam int CW_W  = DATA_W + CRC_W;
  localparam int FIRST = NOM_DLY - SPAN;
  localparam int LAST  = NOM_DLY + SPAN + CW_W - 1;
  localparam int SR_W  = LAST + 1;
  localparam int IDX_W = $clog2(LAST + 2);
  localparam int SEL_W = (N_SLIP > 1) ? $clog2(N_SLIP) : 1;

  logic [IDX_W-1:0]  cnt;
  logic              active;
  logic              fin;
  logic [SR_W-1:0]   sr;
  logic              start_hit;
  logic              take;
  logic              last_hit;
  logic [IDX_W-1:0]  cur_idx;
  logic [N_SLIP-1:0] lane_zero;
  logic              any;
  logic [SEL_W-1:0]  win;
  int                pay_top;

  assign start_hit = bit_vld && burst_start;
  assign take      = bit_vld && (burst_start || active);
  assign cur_idx   = start_hit ? '0 : cnt;
  assign last_hit  = take && (int'(cur_idx) == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
      sr     <= '0;
    end else begin
      fin <= last_hit;
      if (take) begin
        cnt    <= cur_idx + 1'b1;
        active <= !last_hit;
        sr     <= {sr[SR_W-2:0], bit_in};
      end
    end
  end

  for (genvar k = 0; k < N_SLIP; k++) begin : g_lane
    burst_crc_lane #(
      .CRC_W(CRC_W), .CW_W(CW_W), .IDX_W(IDX_W),
      .START(FIRST + k * SLIP_STEP), .POLY(POLY), .INIT(INIT)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(cur_idx),
      .bit_in(bit_in), .rem_zero(lane_zero[k])
    );
  end

  slip_pick #(.N_SLIP(N_SLIP), .SEL_W(SEL_W)) u_pick (
    .zero(lane_zero), .any(any), .win(win)
  );

  assign pay_top     = SR_W - 1 - FIRST - int'(win) * SLIP_STEP;
  assign res_vld     = fin;
  assign res_pass    = fin && any;
  assign res_slip    = res_pass ? SLIP_W'(slipcrc_pkg::lane_slip(int'(win), SLIP_STEP, SPAN)) : '0;
  assign res_payload = res_pass ? sr[pay_top -: DATA_W] : '0;

  // R5: the verdict is a single-cycle strobe
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

  // R5: a verdict only follows a completed window
  a_r5_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> !active);

  // R4: a failing verdict carries no data
  a_r4_fail_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_pass) |-> (res_payload == '0 && res_slip == '0));

  // R6: the selected lane really holds a zero remainder
  a_r6_winner_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> lane_zero[win]);

  // R3: reported slip lies on the symbol grid within the span
  a_r3_slip_grid: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> ($signed(res_slip) >= -SPAN && $signed(res_slip) <= SPAN
                  && ($signed(res_slip) % SLIP_STEP) == 0));

endmodule

// File: tb/tb_slip_crc_checker.sv
module tb_slip_crc_checker;
  localparam int NB   = 117;
  localparam logic [15:0] GEN = 16'hC599;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic        burst_start = 1'b0;
  logic        res_vld;
  logic        res_pass;
  logic [3:0]  res_slip;
  logic [89:0] res_payload;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit finished = 1'b0;
  bit st [0:127];

  always #5 clk = ~clk;

  slip_crc_checker dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .burst_start(burst_start), .res_vld(res_vld), .res_pass(res_pass),
    .res_slip(res_slip), .res_payload(res_payload)
  );

  always @(negedge clk) if (rst_n && res_vld) pulses++;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Long division of the 105-bit window starting at s.
  function automatic bit window_ok(input int s);
    bit w [0:104];
    for (int j = 0; j < 105; j++) w[j] = st[s+j];
    for (int i = 0; i < 90; i++)
      if (w[i]) for (int t = 0; t < 16; t++) w[i+t] ^= GEN[15-t];
    for (int j = 90; j < 105; j++) if (w[j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic place_cw(input int s, input bit lead_zero);
    bit w [0:104];
    for (int j = 0; j < 90; j++) st[s+j] = 1'($urandom);
    if (lead_zero) for (int j = 0; j < 4; j++) st[s+j] = 1'b0;
    for (int j = 0; j < 90; j++) w[j] = st[s+j];
    for (int j = 90; j < 105; j++) w[j] = 1'b0;
    for (int i = 0; i < 90; i++)
      if (w[i]) for (int t = 0; t < 16; t++) w[i+t] ^= GEN[15-t];
    for (int j = 90; j < 105; j++) st[s+j] = w[j];
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < 128; i++) st[i] = (mode == 0) ? 1'($urandom) : 1'b0;
  endtask

  task automatic expect_out(output bit p, output logic [3:0] sl, output logic [89:0] pay);
    int ord [7] = '{3, 2, 4, 1, 5, 0, 6};
    p = 1'b0; sl = 4'd0; pay = '0;
    foreach (ord[q]) begin
      if (!p && window_ok(2 * ord[q])) begin
        p  = 1'b1;
        sl = 4'(2 * ord[q] - 6);
        for (int j = 0; j < 90; j++) pay[89-j] = st[2*ord[q] + j];
      end
    end
  endtask

  task automatic drive_idle_gaps(input int gap_pct);
    while (int'($urandom % 100) < gap_pct) begin
      bit_vld = 1'b0; bit_in = 1'($urandom); burst_start = 1'($urandom);
      @(negedge clk);
      chk(res_vld == 1'b0, "R7 no strobe in gap", 128'(res_vld), 128'd0);
    end
  endtask

  task automatic run_burst(input string req, input int gap_pct, input int extra);
    bit p; logic [3:0] sl; logic [89:0] pay;
    expect_out(p, sl, pay);
    for (int i = 0; i < NB; i++) begin
      drive_idle_gaps(gap_pct);
      bit_vld = 1'b1; bit_in = st[i]; burst_start = (i == 0);
      @(negedge clk);
      if (i == NB - 2) chk(res_vld == 1'b0, "R5 no early strobe", 128'(res_vld), 128'd0);
    end
    bit_vld = 1'b0; burst_start = 1'b0;
    exp_pulses++;
    chk(res_vld == 1'b1, {req, " R5 strobe"}, 128'(res_vld), 128'd1);
    chk(res_pass == p, {req, " pass"}, 128'(res_pass), 128'(p));
    chk(res_slip == sl, {req, " R3 slip"}, 128'(res_slip), 128'(sl));
    chk(res_payload == pay, {req, " R2 payload"}, 128'(res_payload), 128'(pay));
    for (int e = 0; e < extra; e++) begin
      bit_vld = 1'b1; bit_in = 1'($urandom); burst_start = 1'b0;
      @(negedge clk);
      chk(res_vld == 1'b0, "R9 trailing bits ignored", 128'(res_vld), 128'd0);
    end
    bit_vld = 1'b0;
    @(negedge clk);
    chk(res_vld == 1'b0, "R5 strobe one cycle", 128'(res_vld), 128'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(res_vld == 0 && res_pass == 0, "R1 reset flags", 128'({res_vld, res_pass}), 128'd0);
    chk(res_slip == 0 && res_payload == 0, "R1 reset data", 128'(res_payload), 128'd0);

    // R2 nominal codeword in noise
    fill(0); place_cw(6, 1'b0);
    run_burst("R2 nominal", 0, 0);
    chk(res_pass == 1'b0, "R2 idle after verdict", 128'(res_pass), 128'd0);

    // R3 each slip
    for (int k = 0; k < 7; k++) begin
      fill(0); place_cw(2 * k, 1'b0);
      run_burst("R3 slip sweep", 10, 0);
    end

    // R4 corrupted codeword
    fill(0); place_cw(6, 1'b0); st[40] = ~st[40];
    run_burst("R4 corrupted", 0, 0);

    // R6 nested passes: all zeros, then leading-zero codewords in zeros
    fill(1);
    run_burst("R6 all zero", 0, 0);
    fill(1); place_cw(0, 1'b1);
    run_burst("R6 nested at -6", 0, 0);
    fill(1); place_cw(8, 1'b1);
    run_burst("R6 nested at +2", 0, 0);
    fill(1); place_cw(2, 1'b1);
    run_burst("R6 nested at -4", 0, 0);

    // R7 heavy gaps with toggling burst_start while bit_vld low
    fill(0); place_cw(10, 1'b0);
    run_burst("R7 gaps", 60, 0);

    // R8 abandoned burst then restart
    bit_vld = 1'b1; burst_start = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
    for (int i = 0; i < 60; i++) begin bit_in = 1'($urandom); @(negedge clk); end
    bit_vld = 1'b0;
    fill(0); place_cw(4, 1'b0);
    run_burst("R8 restart", 5, 0);

    // R9 trailing bits
    fill(0); place_cw(12, 1'b0);
    run_burst("R9 trailing", 0, 8);

    // random mix
    for (int n = 0; n < 30; n++) begin
      fill(int'($urandom % 4 == 0));
      if ($urandom % 5 != 0) place_cw(2 * int'($urandom % 7), 1'($urandom % 3 == 0));
      run_burst("R3 random", int'($urandom % 30), int'($urandom % 4));
    end

    repeat (3) @(negedge clk);
    chk(pulses == exp_pulses, "R5 R8 one strobe per burst", 128'(pulses), 128'(exp_pulses));
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule